// File: doc/BRIEF.md
# Put-Priority Queue with Fault Pulse

This block is a single-clock first-in first-out queue with a parameterised capacity and data width. Each cycle the user may request an insert, a removal, both, or neither. When an insert and a removal arrive together, the insert takes priority and the removal is dropped. The oldest stored word is always visible on a head output, and the current fill level is visible as a count.

Requests that cannot be served are an insert into a full queue and a removal from an empty queue. Such a request raises a fault flag for exactly the one following cycle. It leaves the stored words, the count and the head value exactly as they were. The queue then keeps working without any recovery step. The head value is meaningless while the count is zero.

Top module: `prio_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `count` = 0 and `fault` = 0.
- R2: An insert while `count` equals DEPTH raises `fault` in the next cycle, keeps `count` and `head_data` unchanged, and drops the offered word, which never appears at the head later.
- R3: An insert while `count` is below DEPTH raises `count` by one in the next cycle, with `fault` low.
- R4: An insert into an empty queue shows the offered word on `head_data` in the next cycle. An insert while 0 < `count` < DEPTH leaves `head_data` unchanged.
- R5: With `wr_req` and `rd_req` both high, the cycle behaves as a pure insert and nothing is removed.
- R6: A removal without insert while `count` is 0 raises `fault` in the next cycle and leaves `count` at 0.
- R7: A removal without insert while `count` > 0 lowers `count` by one in the next cycle, with `fault` low. `head_data` then shows the next oldest word.
- R8: With neither request, `fault` is low in the next cycle, and `count` and `head_data` hold.
- R9: `fault` is high for exactly one cycle per faulty request. The queue serves later requests normally. `count` never exceeds DEPTH.
- R10: Words leave in the order they were inserted. This holds across any number of wraps of the circular storage, also when DEPTH is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Insert request; wins over `rd_req` |
| rd_req | input | 1 | Removal request |
| wr_data | input | WIDTH | Word offered with an insert |
| head_data | output | WIDTH | Oldest stored word; undefined while `count` is 0 |
| count | output | $clog2(DEPTH+1) | Number of stored words |
| fault | output | 1 | One-cycle pulse after an overflow or underflow request |

## Verification
A wrong read or write pointer shows at the ports as a wrong `head_data`. This appears one cycle after the insert into an empty queue, or one cycle after the first removal that reaches the bad slot. A wrong counter is visible on `count` in the very next cycle. It then misfires `fault` at the next boundary request. Long random runs with many wraps of a non-power-of-two depth expose pointer wrap faults within one traversal of the storage.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_PUSH     = 3'd1,
        OP_POP      = 3'd2,
        OP_OVERFLOW = 3'd3,
        OP_UNDERRUN = 3'd4
    } pfq_op_e;

    // Insert has priority over removal; illegal requests become fault ops.
    function automatic pfq_op_e pfq_classify(input logic put, input logic get,
                                             input logic full, input logic empty);
        pfq_op_e op;
        if (put)
            op = full ? OP_OVERFLOW : OP_PUSH;
        else if (get)
            op = empty ? OP_UNDERRUN : OP_POP;
        else
            op = OP_HOLD;
        return op;
    endfunction

    function automatic logic pfq_is_fault(input pfq_op_e op);
        return (op == OP_OVERFLOW) || (op == OP_UNDERRUN);
    endfunction

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             put,
    input  logic             get,
    output pfq_op_e          op,
    output logic [CNT_W-1:0] level,
    output logic             fault
);

    logic full;
    logic empty;

    assign full  = (level == CNT_W'(DEPTH));
    assign empty = (level == '0);
    assign op    = pfq_classify(put, get, full, empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            fault <= 1'b0;
        end else begin
            fault <= pfq_is_fault(op);
            case (op)
                OP_PUSH: level <= level + CNT_W'(1);
                OP_POP:  level <= level - CNT_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/pfq_ptr.sv
module pfq_ptr #(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    logic [PTR_W-1:0] ptr_nxt;

    generate
        if (POW2) begin : g_natural_wrap
            assign ptr_nxt = ptr + PTR_W'(1);
        end else begin : g_compare_wrap
            assign ptr_nxt = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= ptr_nxt;
    end

endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/prio_fifo.sv
module prio_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count,
    output logic             fault
);

    pfq_op_e          op;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = (op == OP_PUSH);
    assign do_pop  = (op == OP_POP);

    pfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .put   (wr_req),
        .get   (rd_req),
        .op    (op),
        .level (count),
        .fault (fault)
    );

    pfq_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .adv (do_push),
        .ptr (wr_ptr)
    );

    pfq_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .adv (do_pop),
        .ptr (rd_ptr)
    );

    pfq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (head_data)
    );

endmodule

// File: rtl/prio_fifo_chk.sv
module prio_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_req,
    input logic             rd_req,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] head_data,
    input logic [CNT_W-1:0] count,
    input logic             fault
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count == '0) && !fault);

    a_r2_full_put: assert property (@(posedge clk) disable iff (rst)
        (wr_req && count == CNT_W'(DEPTH)) |=> fault && $stable(count) && $stable(head_data));

    a_r3_put_grows: assert property (@(posedge clk) disable iff (rst)
        (wr_req && count < CNT_W'(DEPTH)) |=> !fault && (count == $past(count) + CNT_W'(1)));

    a_r4_put_empty_head: assert property (@(posedge clk) disable iff (rst)
        (wr_req && count == '0) |=> head_data == $past(wr_data));

    a_r4_put_keeps_head: assert property (@(posedge clk) disable iff (rst)
        (wr_req && count != '0 && count < CNT_W'(DEPTH)) |=> $stable(head_data));

    a_r6_empty_get: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && count == '0) |=> fault && (count == '0));

    a_r7_get_shrinks: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && count != '0) |=> !fault && (count == $past(count) - CNT_W'(1)));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_req && !rd_req) |=> !fault && $stable(count) && ((count == '0) || $stable(head_data)));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

endmodule

bind prio_fifo prio_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .wr_data   (wr_data),
    .head_data (head_data),
    .count     (count),
    .fault     (fault)
);

// File: tb/prio_fifo_tb.sv
module prio_fifo_tb;

    localparam int D     = 5;
    localparam int W     = 8;
    localparam int CW    = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  head_data;
    logic [CW-1:0] count;
    logic          fault;

    int n_checks = 0;
    int n_fail   = 0;
    int q[$];
    bit exp_fault = 1'b0;

    always #2.5 clk = ~clk;

    prio_fifo #(.DEPTH(D), .WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .wr_data   (wr_data),
        .head_data (head_data),
        .count     (count),
        .fault     (fault)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string pick_tag(input bit p, input bit g, input int sz);
        if (p && sz == D) return "R2";
        if (p && g)       return "R5";
        if (p)            return "R3";
        if (g && sz == 0) return "R6";
        if (g)            return "R7";
        return "R8";
    endfunction

    task automatic do_reset();
        rst = 1'b1; wr_req = 1'b0; rd_req = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        q.delete();
        exp_fault = 1'b0;
        check("R1", "count after reset", int'(count), 0);
        check("R1", "fault after reset", int'(fault), 0);
    endtask

    task automatic step(input bit p, input bit g, input logic [W-1:0] d);
        string tag;
        bit    was_empty;
        tag = pick_tag(p, g, q.size());
        was_empty = (q.size() == 0);
        wr_req = p; rd_req = g; wr_data = d;
        @(posedge clk); #1;
        if (p) begin
            if (q.size() == D) exp_fault = 1'b1;
            else begin q.push_back(int'(d)); exp_fault = 1'b0; end
        end else if (g) begin
            if (q.size() == 0) exp_fault = 1'b1;
            else begin void'(q.pop_front()); exp_fault = 1'b0; end
        end else begin
            exp_fault = 1'b0;
        end
        check(tag, "count", int'(count), q.size());
        check(exp_fault ? tag : "R9", "fault", int'(fault), int'(exp_fault));
        if (q.size() > 0) begin
            if (p && was_empty) check("R4", "head", int'(head_data), q[0]);
            else                check("R10", "head order", int'(head_data), q[0]);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        do_reset();
        // R4 put into empty, then fill to full (R3)
        step(1, 0, 8'h11);
        step(1, 0, 8'h22);
        step(1, 1, 8'h33);            // R5 put wins
        step(1, 0, 8'h44);
        step(1, 0, 8'h55);
        // R2 overflow, dropped word, repeated pulses
        step(1, 0, 8'hEE);
        step(1, 0, 8'hEF);
        step(1, 1, 8'hF0);            // R2/R5 on full
        step(0, 0, 8'h00);            // R8, R9 pulse ended
        // R7 drain in order, R6 underflow twice
        for (int i = 0; i < D; i++) step(0, 1, 8'h00);
        step(0, 1, 8'h00);
        step(0, 1, 8'h00);
        step(0, 0, 8'h00);
        step(1, 0, 8'h5A);            // R4 after underflow, R9 recovery
        // Random mix; many wraps for R10
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 40, (r >= 30 && r < 80), W'($urandom()));
            if (i == 2000) do_reset();  // R1 mid-run
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule